// File: doc/BRIEF.md
# Memory-Mapped Interrupt Status Controller

This block gathers single-cycle request pulses from a parameterised set of peripheral sources into a sticky status register. A software-programmable mask register selects which pending sources may interrupt the processor. The block drives one level-sensitive interrupt line whenever a pending source is also enabled. A second output reports whether anything is pending at all, whatever the mask says. Software reaches both registers through a small register bus with read and write strobes, a byte offset, and 32-bit data in each direction.

Software acknowledges by writing the status register. The written word is ANDed into the current contents, so a 0 bit clears that source and a 1 bit leaves it alone. The processor line comes from a two-state machine. It sits in `LINE_LOW` and takes the `RAISE` transition to `LINE_HIGH` when the masked status becomes nonzero. It takes the `DROP` transition back to `LINE_LOW` when the masked status is zero again. Each transition happens one clock after the register change that causes it.

Top module: `irq_status_ctrl`

## Requirements
- R1: The status register sits at offset 0x00 and the mask register at offset 0x04. A read strobe places the selected register, zero-extended to 32 bits, on `rd_data` after the next clock edge. The value read is the one held before any write in that same cycle.
- R2: A pulse on `src_req[n]` sets status bit n on the next clock edge. The bit stays set until software clears it.
- R3: A write to offset 0x00 makes each implemented status bit equal to its old value ANDed with the matching write-data bit. Written 0s clear bits and written 1s keep them.
- R4: A write to offset 0x04 stores only the low `NUM_SRC` data bits into the mask. Bits at and above `NUM_SRC` read as 0 in both registers.
- R5: After reset, status, mask, `irq_out`, `any_pending`, `rd_data` and `bus_err` are all 0, so every source starts masked.
- R6: `irq_out` is 1 exactly when status AND mask was nonzero after the previous clock edge. It therefore lags the register change that causes it by one cycle.
- R7: `any_pending` is 1 whenever any status bit is set, regardless of the mask, with no added delay.
- R8: If a request pulse for bit n arrives in the same cycle as a status write that clears bit n, the bit ends up set.
- R9: A read of any offset other than 0x00 and 0x04 returns 0xFFFFFFFF. A write to such an offset changes neither register.
- R10: Any read or write to an unmapped offset raises `bus_err` for exactly the one cycle after that access. A mapped access leaves it low.
- R11: The line machine moves `LINE_LOW` to `LINE_HIGH` (RAISE) and `LINE_HIGH` to `LINE_LOW` (DROP) only as R6 demands. In all other cycles it holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_off | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `bus_rd` |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| src_req | input | NUM_SRC | Per-source single-cycle request pulses |
| irq_out | output | 1 | Masked, registered interrupt line to the processor |
| any_pending | output | 1 | Raw OR of all status bits |

## Verification
The bench sends a request pulse together with a status write that clears the same bit. A design that let the write win would lose the interrupt and report the bit clear. It writes all ones to the mask and reads it back, where a design without width restriction would return set upper bits. It accesses unmapped offsets, where a faulty decoder would alter a register, return data other than all ones, or hold the error flag for more than one cycle. The behavioural model also catches an interrupt line that follows the masked status one cycle early or late, or that follows the raw status and ignores the mask.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned OFF_STATUS = 32'h00;
    localparam int unsigned OFF_MASK   = 32'h04;

    typedef enum logic {
        LINE_LOW  = 1'b0,
        LINE_HIGH = 1'b1
    } line_state_t;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode #(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_rd,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_off,
    input  logic [NUM_SRC-1:0]          status_q,
    input  logic [NUM_SRC-1:0]          mask_q,
    output logic                        wr_status,
    output logic                        wr_mask,
    output logic [irq_pkg::DATA_W-1:0]  rd_data,
    output logic                        bus_err
);
    localparam int unsigned           DW     = irq_pkg::DATA_W;
    localparam logic [ADDR_W-1:0]     OFF_ST = ADDR_W'(irq_pkg::OFF_STATUS);
    localparam logic [ADDR_W-1:0]     OFF_MK = ADDR_W'(irq_pkg::OFF_MASK);

    logic          hit_status;
    logic          hit_mask;
    logic          unmapped;
    logic [DW-1:0] rd_next;

    assign hit_status = (bus_off == OFF_ST);
    assign hit_mask   = (bus_off == OFF_MK);
    assign unmapped   = !hit_status && !hit_mask;
    assign wr_status  = bus_wr && hit_status;
    assign wr_mask    = bus_wr && hit_mask;

    always_comb begin
        if (hit_status)    rd_next = DW'(status_q);
        else if (hit_mask) rd_next = DW'(mask_q);
        else               rd_next = '1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            bus_err <= 1'b0;
        end else begin
            if (bus_rd) rd_data <= rd_next;
            bus_err <= (bus_rd || bus_wr) && unmapped;
        end
    end

    // R9: unmapped read returns all ones
    a_r9_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (rd_data == '1));

    // R10: mapped access never raises the error flag
    a_r10_mapped_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !unmapped) |=> !bus_err);
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_req,
    input  logic               wr_status,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] status_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)          status_q[i] <= 1'b0;
            else if (src_req[i]) status_q[i] <= 1'b1;
            else if (wr_status)  status_q[i] <= status_q[i] & wdata[i];
        end

        // R2 / R8: a request sets its bit even against a clearing write
        a_r8_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[i] |=> status_q[i]);
    end

    // R3: write ANDs into the bits not being requested
    a_r3_and_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status_q & ~$past(src_req)) ==
                       ($past(status_q) & $past(wdata) & ~$past(src_req))));

    // R2: without write, bits never fall
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_status |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_mask,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= wdata;
    end

    // R9 / R4: mask changes only on a mapped mask write
    a_r9_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm #(
    parameter int unsigned NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_q,
    input  logic [NUM_SRC-1:0] mask_q,
    output logic               irq_out
);
    import irq_pkg::*;

    line_state_t state_q;
    line_state_t state_d;
    logic        hit;

    assign hit = |(status_q & mask_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_LOW:  if (hit)  state_d = LINE_HIGH;
            LINE_HIGH: if (!hit) state_d = LINE_LOW;
            default:             state_d = LINE_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LINE_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_out = (state_q == LINE_HIGH);
    end

    // R6: line follows masked status one clock later
    a_r6_line_lag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(|(status_q & mask_q))));

    // R11: RAISE only when masked status was nonzero
    a_r11_raise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(hit));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
    parameter int unsigned NUM_SRC = 11,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_rd,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_off,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                rd_data,
    output logic                       bus_err,
    input  logic [NUM_SRC-1:0]         src_req,
    output logic                       irq_out,
    output logic                       any_pending
);
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic               wr_status;
    logic               wr_mask;
    logic [NUM_SRC-1:0] wdata_lo;

    assign wdata_lo    = bus_wdata[NUM_SRC-1:0];
    assign any_pending = |status_q;

    irq_bus_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_off(bus_off), .status_q(status_q), .mask_q(mask_q),
        .wr_status(wr_status), .wr_mask(wr_mask),
        .rd_data(rd_data), .bus_err(bus_err)
    );

    irq_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk(clk), .rst_n(rst_n), .src_req(src_req),
        .wr_status(wr_status), .wdata(wdata_lo), .status_q(status_q)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask),
        .wdata(wdata_lo), .mask_q(mask_q)
    );

    irq_line_fsm #(.NUM_SRC(NUM_SRC)) u_line (
        .clk(clk), .rst_n(rst_n), .status_q(status_q),
        .mask_q(mask_q), .irq_out(irq_out)
    );

    // R10: error flag lasts a single cycle unless re-triggered
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !bus_rd && !bus_wr) |=> !bus_err);

    // R7: raw pending drops only through a status write
    a_r7_pending_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_pending) |-> $past(bus_wr));
endmodule

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 11;
    localparam int AW         = 8;
    localparam int MAX_CYC    = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_off = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   rd_data;
    logic          bus_err;
    logic [N-1:0]  src_req = '0;
    logic          irq_out;
    logic          any_pending;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    // behavioural reference state
    int unsigned m_stat = 0, m_mask = 0, m_rd = 0;
    bit          m_err = 0, m_irq = 0;
    int unsigned lo_mask;

    irq_status_ctrl #(.NUM_SRC(N), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .bus_err(bus_err), .src_req(src_req), .irq_out(irq_out),
        .any_pending(any_pending)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    initial lo_mask = (32'd1 << N) - 1;

    // reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_mask = 0; m_rd = 0; m_err = 0; m_irq = 0;
        end else begin
            bit bad;
            bad   = (bus_off != 8'h00) && (bus_off != 8'h04);
            m_irq = ((m_stat & m_mask) != 0);
            if (bus_rd)
                m_rd = (bus_off == 8'h00) ? m_stat :
                       (bus_off == 8'h04) ? m_mask : 32'hFFFF_FFFF;
            m_err = (bus_rd || bus_wr) && bad;
            if (bus_wr && bus_off == 8'h04) m_mask = bus_wdata & lo_mask;
            if (bus_wr && bus_off == 8'h00) m_stat = m_stat & bus_wdata & lo_mask;
            m_stat = m_stat | 32'(src_req);
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rd_data == m_rd, "R1 rd_data vs model", rd_data, m_rd);
            check(bus_err == m_err, "R10 bus_err vs model", 32'(bus_err), 32'(m_err));
            check(irq_out == m_irq, "R6 irq_out vs model", 32'(irq_out), 32'(m_irq));
            check(any_pending == (m_stat != 0), "R7 any_pending vs model",
                  32'(any_pending), 32'(m_stat != 0));
        end
    end

    task automatic step(input bit rd, input bit wr, input int unsigned off,
                        input int unsigned wd, input int unsigned req);
        bus_rd = rd; bus_wr = wr; bus_off = AW'(off);
        bus_wdata = wd; src_req = N'(req);
        @(posedge clk);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; src_req = '0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, MAX_CYC);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R5: reset values visible while held in reset
        check(irq_out == 0 && any_pending == 0 && bus_err == 0 && rd_data == 0,
              "R5 reset outputs", {irq_out, any_pending, bus_err}, 0);
        rst_n = 1;
        @(negedge clk);
        step(1, 0, 8'h04, 0, 0);
        check(rd_data == 0, "R5 mask zero after reset", rd_data, 0);

        // R2, R7: pulse sets sticky bit, raw pending up, line masked
        step(0, 0, 0, 0, 32'h8);
        check(any_pending == 1, "R7 raw pending", 32'(any_pending), 1);
        idle(); idle();
        check(irq_out == 0, "R5 masked by default", 32'(irq_out), 0);
        step(1, 0, 8'h00, 0, 0);
        check(rd_data == 32'h8, "R2 sticky bit", rd_data, 32'h8);

        // R4: mask write restricted; R6 line lags one cycle
        step(0, 1, 8'h04, 32'hFFFF_FFFF, 0);
        check(irq_out == 0, "R6 line not yet up", 32'(irq_out), 0);
        idle();
        check(irq_out == 1, "R11 RAISE after one cycle", 32'(irq_out), 1);
        step(1, 0, 8'h04, 0, 0);
        check(rd_data == lo_mask, "R4 mask upper bits zero", rd_data, lo_mask);

        // R3: AND write clears only zeroed bit
        step(0, 0, 0, 0, 32'h401);
        step(0, 1, 8'h00, 32'hFFFF_FFF7, 0);
        step(1, 0, 8'h00, 0, 0);
        check(rd_data == 32'h401, "R3 AND write", rd_data, 32'h401);

        // R8: request beats a clearing write
        step(0, 1, 8'h00, 32'h0, 32'h1);
        step(1, 0, 8'h00, 0, 0);
        check(rd_data == 32'h1, "R8 request wins", rd_data, 32'h1);

        // R9, R10: unmapped read and write
        step(1, 0, 8'h08, 0, 0);
        check(rd_data == 32'hFFFF_FFFF, "R9 unmapped read", rd_data, 32'hFFFF_FFFF);
        check(bus_err == 1, "R10 err on unmapped read", 32'(bus_err), 1);
        step(0, 1, 8'h0C, 32'h0, 0);
        check(bus_err == 1, "R10 err on unmapped write", 32'(bus_err), 1);
        idle();
        check(bus_err == 0, "R10 err one cycle", 32'(bus_err), 0);
        step(1, 0, 8'h04, 0, 0);
        check(rd_data == lo_mask, "R9 unmapped write ignored (mask)", rd_data, lo_mask);
        step(1, 0, 8'h00, 0, 0);
        check(rd_data == 32'h1, "R9 unmapped write ignored (status)", rd_data, 32'h1);

        // R1: read returns pre-write value in same cycle
        step(1, 1, 8'h00, 32'h0, 0);
        check(rd_data == 32'h1, "R1 read old value", rd_data, 32'h1);
        idle();
        check(irq_out == 0 && any_pending == 0, "R11 DROP after clear",
              {irq_out, any_pending}, 0);

        // random traffic compared against the model each cycle
        for (int i = 0; i < 2000; i++) begin
            int unsigned r;
            int unsigned off;
            r   = $urandom;
            off = (r[3:0] < 6) ? 8'h00 : (r[3:0] < 11) ? 8'h04 : (r[7:4] << 2) | r[9:8];
            step(r[10], r[11] & r[12], off, $urandom,
                 (r[15:13] == 0) ? $urandom : 0);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule